// File: doc/BRIEF.md
# Pattern-Matching Instruction Decoder

This block turns a 32-bit RV64 instruction word into the control lines a single-cycle datapath needs. A combinational slicer cuts the word into its opcode, function and register-index fields. It then runs one comparator per supported instruction against a constant pattern. Depending on the entry, a comparator looks at the opcode alone, or adds the 3-bit function field, the 7-bit function field, or the 6-bit shift function field. The hit vector goes through a lowest-index-wins priority encoder, so overlapping patterns resolve to one entry. The chosen index addresses a control ROM whose word carries the mux selects, the ALU operation and the write enables.

The pattern table and the ROM contents are parameters, so the supported instruction subset can change without touching the decode logic. The unimp encoding has its own comparator. When it is seen while the core runs, it sets a halt flag that stays set until reset. Register writes, memory writes and PC updates are held off while the run enable is low or the halt flag is set. The decoded control word stays visible at all times, for inspection.

Top module: `instr_decoder`

## Requirements
- R1: `rs1`, `rs2` and `rd` equal instruction bits [19:15], [24:20] and [11:7] in the same cycle, for any word.
- R2: Each supported instruction drives its own control word onto `ctrlWord`, combinationally. The field layout, LSB first, is: opWord[0], brCond[3:1], memUnsigned[4], memSize[6:5], immKind[9:7], aluOp[13:10], aluSrcImm[14], pcSel[16:15], wbSel[18:17], memRead[19]. The encodings are: aluOp ADD=0 SUB=1 AND=2 SLL=5 SRL=6 SRA=7 PASSB=10; immKind none=0 I=1 S=2 B=3 U=4 J=5; wbSel ALU=0 memory=1 PC+4=2 PC+imm=3; pcSel sequential=0 conditional=1 jump=2 register-jump=3. brCond equals the branch's 3-bit function field.
- R3: Opcode 0010011 with function 001 is a left shift only when bits [31:26] are 000000. With function 101, bits [31:26] = 010000 give an arithmetic right shift.
- R4: When several patterns hit, the lowest table index wins. With function 101, a right-shift immediate whose bits [31:26] are not 010000 still decodes as a logical right shift, because that entry ignores the 6-bit field and the arithmetic entry sits before it.
- R5: A word that hits no pattern and is not unimp gives `valid`=0, `illegal`=1, an all-zero `ctrlWord` and no write strobes. A word that hits a pattern gives `valid`=1 and `illegal`=0.
- R6: The unimp word 32'hC0001073 gives `valid`=0, `illegal`=0, an all-zero `ctrlWord` and no write strobes.
- R7: `halt` rises on the first clock edge at which unimp is present with `runEn` high. It then stays high until reset. Unimp with `runEn` low does not set it.
- R8: While `runEn` is low or `halt` is high, `regWrite`, `memWrite` and `pcUpdate` are 0, and `ctrlWord` and `valid` still reflect the decode. Otherwise `regWrite`/`memWrite` follow the entry's enables, and `pcUpdate` equals `valid`.
- R9: While `rst` is high at a clock edge, `halt` is cleared. The first edge of reset already leaves `halt` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the halt flag |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word to decode |
| runEn | input | 1 | Run enable; gates all state-changing strobes |
| ctrlWord | output | 20 | Decoded non-write control fields (layout in R2) |
| regWrite | output | 1 | Gated register-file write enable |
| memWrite | output | 1 | Gated data-memory write enable |
| pcUpdate | output | 1 | Gated program-counter update |
| rs1 | output | 5 | First source register index |
| rs2 | output | 5 | Second source register index |
| rd | output | 5 | Destination register index |
| valid | output | 1 | Word matched a supported pattern |
| illegal | output | 1 | Word matched nothing and is not unimp |
| halt | output | 1 | Sticky stop flag raised by unimp |

## Verification
Every path except the halt flag is combinational. A wrong comparator, a wrong priority order or a corrupt ROM entry therefore shows on `ctrlWord`, `valid` or `illegal` in the same cycle the offending word is applied. The bench compares every cycle against a reference decoder written as plain field tests. A stray halt flag differs at the first edge after the cause: the write strobes stay suppressed on every later cycle until reset, so a wrong set or clear is caught within one cycle and keeps failing.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  localparam int DEF_COUNT = 26;
  localparam logic [31:0] UNIMP_WORD = 32'hC0001073;

  typedef enum logic [1:0] {CMP_OP, CMP_F3, CMP_F7, CMP_F6} cmp_mode_e;

  typedef struct packed {
    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;
    cmp_mode_e  mode;
  } pat_t;

  localparam int PAT_W = $bits(pat_t);

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_SLL = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_SLT = 4'd8, ALU_SLTU = 4'd9, ALU_PASSB = 4'd10
  } alu_e;

  typedef enum logic [2:0] {
    IMM_NONE = 3'd0, IMM_I = 3'd1, IMM_S = 3'd2, IMM_B = 3'd3, IMM_U = 3'd4, IMM_J = 3'd5
  } imm_e;

  typedef struct packed {
    logic       memRead;
    logic [1:0] wbSel;
    logic [1:0] pcSel;
    logic       aluSrcImm;
    alu_e       aluOp;
    imm_e       immKind;
    logic [1:0] memSize;
    logic       memUnsigned;
    logic [2:0] brCond;
    logic       opWord;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic  regWrite;
    logic  memWrite;
    ctrl_t ctrl;
  } rom_t;

  localparam int ROM_W = $bits(rom_t);

  // strobes from the sequencing control into the lookup datapath
  typedef struct packed {
    logic commitOk;
    logic halted;
  } gate_t;

  function automatic pat_t mkPat(logic [6:0] op, logic [2:0] f3, logic [6:0] f7, cmp_mode_e m);
    pat_t p;
    p.opcode = op;
    p.funct3 = f3;
    p.funct7 = f7;
    p.mode   = m;
    return p;
  endfunction

  function automatic rom_t mkRom(logic rw, logic mw, logic mr, logic [1:0] wb, logic [1:0] pc,
                                 logic src, alu_e alu, imm_e imm, logic [1:0] sz, logic uns,
                                 logic [2:0] br, logic word);
    rom_t r;
    r.regWrite         = rw;
    r.memWrite         = mw;
    r.ctrl.memRead     = mr;
    r.ctrl.wbSel       = wb;
    r.ctrl.pcSel       = pc;
    r.ctrl.aluSrcImm   = src;
    r.ctrl.aluOp       = alu;
    r.ctrl.immKind     = imm;
    r.ctrl.memSize     = sz;
    r.ctrl.memUnsigned = uns;
    r.ctrl.brCond      = br;
    r.ctrl.opWord      = word;
    return r;
  endfunction

  // Index order is priority order: lower index wins on overlap.
  function automatic logic [DEF_COUNT*PAT_W-1:0] defaultPats();
    logic [DEF_COUNT*PAT_W-1:0] t;
    t = '0;
    t[ 0*PAT_W +: PAT_W] = mkPat(7'b0110111, 3'd0, 7'd0, CMP_OP);        // lui
    t[ 1*PAT_W +: PAT_W] = mkPat(7'b0010111, 3'd0, 7'd0, CMP_OP);        // auipc
    t[ 2*PAT_W +: PAT_W] = mkPat(7'b1101111, 3'd0, 7'd0, CMP_OP);        // jal
    t[ 3*PAT_W +: PAT_W] = mkPat(7'b1100111, 3'd0, 7'd0, CMP_F3);        // jalr
    t[ 4*PAT_W +: PAT_W] = mkPat(7'b1100011, 3'd0, 7'd0, CMP_F3);        // beq
    t[ 5*PAT_W +: PAT_W] = mkPat(7'b1100011, 3'd1, 7'd0, CMP_F3);        // bne
    t[ 6*PAT_W +: PAT_W] = mkPat(7'b1100011, 3'd4, 7'd0, CMP_F3);        // blt
    t[ 7*PAT_W +: PAT_W] = mkPat(7'b1100011, 3'd5, 7'd0, CMP_F3);        // bge
    t[ 8*PAT_W +: PAT_W] = mkPat(7'b1100011, 3'd6, 7'd0, CMP_F3);        // bltu
    t[ 9*PAT_W +: PAT_W] = mkPat(7'b1100011, 3'd7, 7'd0, CMP_F3);        // bgeu
    t[10*PAT_W +: PAT_W] = mkPat(7'b0000011, 3'd0, 7'd0, CMP_F3);        // lb
    t[11*PAT_W +: PAT_W] = mkPat(7'b0000011, 3'd2, 7'd0, CMP_F3);        // lw
    t[12*PAT_W +: PAT_W] = mkPat(7'b0000011, 3'd3, 7'd0, CMP_F3);        // ld
    t[13*PAT_W +: PAT_W] = mkPat(7'b0000011, 3'd4, 7'd0, CMP_F3);        // lbu
    t[14*PAT_W +: PAT_W] = mkPat(7'b0100011, 3'd0, 7'd0, CMP_F3);        // sb
    t[15*PAT_W +: PAT_W] = mkPat(7'b0100011, 3'd2, 7'd0, CMP_F3);        // sw
    t[16*PAT_W +: PAT_W] = mkPat(7'b0100011, 3'd3, 7'd0, CMP_F3);        // sd
    t[17*PAT_W +: PAT_W] = mkPat(7'b0010011, 3'd0, 7'd0, CMP_F3);        // addi
    t[18*PAT_W +: PAT_W] = mkPat(7'b0010011, 3'd7, 7'd0, CMP_F3);        // andi
    t[19*PAT_W +: PAT_W] = mkPat(7'b0010011, 3'd1, 7'b0000000, CMP_F6);  // slli
    t[20*PAT_W +: PAT_W] = mkPat(7'b0010011, 3'd5, 7'b0100000, CMP_F6);  // srai
    t[21*PAT_W +: PAT_W] = mkPat(7'b0010011, 3'd5, 7'd0, CMP_F3);        // srli, relies on priority
    t[22*PAT_W +: PAT_W] = mkPat(7'b0110011, 3'd0, 7'b0000000, CMP_F7);  // add
    t[23*PAT_W +: PAT_W] = mkPat(7'b0110011, 3'd0, 7'b0100000, CMP_F7);  // sub
    t[24*PAT_W +: PAT_W] = mkPat(7'b0110011, 3'd7, 7'b0000000, CMP_F7);  // and
    t[25*PAT_W +: PAT_W] = mkPat(7'b0111011, 3'd0, 7'b0000000, CMP_F7);  // addw
    return t;
  endfunction

  function automatic logic [DEF_COUNT*ROM_W-1:0] defaultRom();
    logic [DEF_COUNT*ROM_W-1:0] t;
    logic [2:0] brF3 [6];
    logic [1:0] ldSz [4];
    logic [1:0] stSz [3];
    brF3 = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
    ldSz = '{2'd0, 2'd2, 2'd3, 2'd0};
    stSz = '{2'd0, 2'd2, 2'd3};
    t = '0;
    t[ 0*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 1, ALU_PASSB, IMM_U, 2'd0, 0, 3'd0, 0);
    t[ 1*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd3, 2'd0, 1, ALU_ADD, IMM_U, 2'd0, 0, 3'd0, 0);
    t[ 2*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd2, 2'd2, 0, ALU_ADD, IMM_J, 2'd0, 0, 3'd0, 0);
    t[ 3*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd2, 2'd3, 1, ALU_ADD, IMM_I, 2'd0, 0, 3'd0, 0);
    for (int b = 0; b < 6; b++)
      t[(4+b)*ROM_W +: ROM_W] = mkRom(0, 0, 0, 2'd0, 2'd1, 0, ALU_SUB, IMM_B, 2'd0, 0, brF3[b], 0);
    for (int l = 0; l < 4; l++)
      t[(10+l)*ROM_W +: ROM_W] = mkRom(1, 0, 1, 2'd1, 2'd0, 1, ALU_ADD, IMM_I, ldSz[l], l == 3, 3'd0, 0);
    for (int s = 0; s < 3; s++)
      t[(14+s)*ROM_W +: ROM_W] = mkRom(0, 1, 0, 2'd0, 2'd0, 1, ALU_ADD, IMM_S, stSz[s], 0, 3'd0, 0);
    t[17*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 1, ALU_ADD, IMM_I, 2'd0, 0, 3'd0, 0);
    t[18*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 1, ALU_AND, IMM_I, 2'd0, 0, 3'd0, 0);
    t[19*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 1, ALU_SLL, IMM_I, 2'd0, 0, 3'd0, 0);
    t[20*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 1, ALU_SRA, IMM_I, 2'd0, 0, 3'd0, 0);
    t[21*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 1, ALU_SRL, IMM_I, 2'd0, 0, 3'd0, 0);
    t[22*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 0, ALU_ADD, IMM_NONE, 2'd0, 0, 3'd0, 0);
    t[23*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 0, ALU_SUB, IMM_NONE, 2'd0, 0, 3'd0, 0);
    t[24*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 0, ALU_AND, IMM_NONE, 2'd0, 0, 3'd0, 0);
    t[25*ROM_W +: ROM_W] = mkRom(1, 0, 0, 2'd0, 2'd0, 0, ALU_ADD, IMM_NONE, 2'd0, 0, 3'd0, 1);
    return t;
  endfunction

endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import instr_dec_pkg::*;
#(
  parameter int NUM_INSTR = DEF_COUNT,
  parameter logic [NUM_INSTR*PAT_W-1:0] PAT_TABLE = defaultPats()
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          instr,
  output logic [4:0]           rs1,
  output logic [4:0]           rs2,
  output logic [4:0]           rd,
  output logic [NUM_INSTR-1:0] matchVec,
  output logic                 isUnimp
);

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic [5:0] funct6;

  assign opcode = instr[6:0];
  assign rd     = instr[11:7];
  assign funct3 = instr[14:12];
  assign rs1    = instr[19:15];
  assign rs2    = instr[24:20];
  assign funct7 = instr[31:25];
  assign funct6 = instr[31:26];

  assign isUnimp = (instr == UNIMP_WORD);

  for (genvar g = 0; g < NUM_INSTR; g++) begin : gCmp
    localparam pat_t P = pat_t'(PAT_TABLE[g*PAT_W +: PAT_W]);
    logic opHit, f3Hit, f7Hit, f6Hit;
    assign opHit = (opcode == P.opcode);
    assign f3Hit = (funct3 == P.funct3);
    assign f7Hit = (funct7 == P.funct7);
    assign f6Hit = (funct6 == P.funct7[6:1]);
    assign matchVec[g] = opHit &&
                         (P.mode == CMP_OP ||
                          (f3Hit && (P.mode == CMP_F3 ||
                                     (P.mode == CMP_F7 && f7Hit) ||
                                     (P.mode == CMP_F6 && f6Hit))));
  end

  AST_UNIMP_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    isUnimp |-> (matchVec == '0)); // R6

endmodule

// File: rtl/dec_seq.sv
module dec_seq
  import instr_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  runEn,
  input  logic  isUnimp,
  output gate_t gate
);

  logic haltQ;

  always_ff @(posedge clk) begin
    if (rst) haltQ <= 1'b0;
    else     haltQ <= haltQ | (runEn & isUnimp);
  end

  assign gate.halted   = haltQ;
  assign gate.commitOk = runEn & ~haltQ;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    haltQ |=> haltQ); // R7

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(haltQ) |-> $past(runEn && isUnimp)); // R7

endmodule

// File: rtl/dec_rom.sv
module dec_rom
  import instr_dec_pkg::*;
#(
  parameter int NUM_INSTR = DEF_COUNT,
  parameter logic [NUM_INSTR*ROM_W-1:0] ROM_TABLE = defaultRom()
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_INSTR-1:0] matchVec,
  input  logic                 isUnimp,
  input  gate_t                gate,
  output ctrl_t                ctrlOut,
  output logic                 regWrite,
  output logic                 memWrite,
  output logic                 pcUpdate,
  output logic                 valid,
  output logic                 illegal
);

  localparam int IDX_W = (NUM_INSTR > 1) ? $clog2(NUM_INSTR) : 1;

  logic [IDX_W-1:0]     idx;
  logic [NUM_INSTR-1:0] lowestBit;
  logic                 hit;
  rom_t                 romWord;

  // priority encoder: scan downward so the lowest set index is kept
  always_comb begin
    idx = '0;
    for (int i = NUM_INSTR - 1; i >= 0; i--) begin
      if (matchVec[i]) idx = IDX_W'(i);
    end
  end

  assign lowestBit = matchVec & (~matchVec + NUM_INSTR'(1));
  assign hit       = |matchVec;
  assign romWord   = rom_t'(ROM_TABLE[idx*ROM_W +: ROM_W]);

  assign ctrlOut  = hit ? romWord.ctrl : '0;
  assign regWrite = hit & romWord.regWrite & gate.commitOk;
  assign memWrite = hit & romWord.memWrite & gate.commitOk;
  assign pcUpdate = hit & gate.commitOk;
  assign valid    = hit;
  assign illegal  = ~hit & ~isUnimp;

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    hit |-> lowestBit[idx]); // R4

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (ctrlOut == '0 && !regWrite && !memWrite && !pcUpdate)); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(valid && illegal)); // R5

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    gate.halted |-> (!regWrite && !memWrite && !pcUpdate)); // R8

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int NUM_INSTR = DEF_COUNT,
  parameter logic [NUM_INSTR*PAT_W-1:0] PAT_TABLE = defaultPats(),
  parameter logic [NUM_INSTR*ROM_W-1:0] ROM_TABLE = defaultRom()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr,
  input  logic              runEn,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              regWrite,
  output logic              memWrite,
  output logic              pcUpdate,
  output logic [4:0]        rs1,
  output logic [4:0]        rs2,
  output logic [4:0]        rd,
  output logic              valid,
  output logic              illegal,
  output logic              halt
);

  logic [NUM_INSTR-1:0] matchVec;
  logic                 isUnimp;
  gate_t                gate;
  ctrl_t                ctrlOut;

  dec_fields #(.NUM_INSTR(NUM_INSTR), .PAT_TABLE(PAT_TABLE)) uFields (
    .clk(clk), .rst(rst), .instr(instr),
    .rs1(rs1), .rs2(rs2), .rd(rd),
    .matchVec(matchVec), .isUnimp(isUnimp)
  );

  dec_seq uSeq (
    .clk(clk), .rst(rst), .runEn(runEn), .isUnimp(isUnimp), .gate(gate)
  );

  dec_rom #(.NUM_INSTR(NUM_INSTR), .ROM_TABLE(ROM_TABLE)) uRom (
    .clk(clk), .rst(rst), .matchVec(matchVec), .isUnimp(isUnimp), .gate(gate),
    .ctrlOut(ctrlOut), .regWrite(regWrite), .memWrite(memWrite), .pcUpdate(pcUpdate),
    .valid(valid), .illegal(illegal)
  );

  assign ctrlWord = ctrlOut;
  assign halt     = gate.halted;

endmodule

// File: tb/instr_decoder_test.sv
module instr_decoder_test;

  localparam logic [31:0] UNIMP = 32'hC0001073;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        runEn = 1'b0;
  logic [19:0] ctrlWord;
  logic        regWrite, memWrite, pcUpdate, valid, illegal, halt;
  logic [4:0]  rs1, rs2, rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic haltModel = 1'b0;

  always #5 clk = ~clk;

  instr_decoder uut (
    .clk(clk), .rst(rst), .instr(instr), .runEn(runEn),
    .ctrlWord(ctrlWord), .regWrite(regWrite), .memWrite(memWrite), .pcUpdate(pcUpdate),
    .rs1(rs1), .rs2(rs2), .rd(rd), .valid(valid), .illegal(illegal), .halt(halt)
  );

  // behavioural halt model (R7, R9)
  always @(posedge clk) begin
    if (rst) haltModel <= 1'b0;
    else     haltModel <= haltModel | (runEn && instr == UNIMP);
  end

  function automatic logic [19:0] pk(logic mr, logic [1:0] wb, logic [1:0] pc, logic src,
                                     logic [3:0] alu, logic [2:0] imm, logic [1:0] sz,
                                     logic uns, logic [2:0] br, logic wd);
    return {mr, wb, pc, src, alu, imm, sz, uns, br, wd};
  endfunction

  // returns {valid, illegal, regWriteRaw, memWriteRaw, ctrl[19:0]}
  function automatic logic [23:0] refDecode(logic [31:0] w);
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    logic ok = 1'b1, rw = 1'b0, mw = 1'b0;
    logic [19:0] c = '0;
    case (op)
      7'b0110111: begin rw = 1; c = pk(0, 0, 0, 1, 10, 4, 0, 0, 0, 0); end
      7'b0010111: begin rw = 1; c = pk(0, 3, 0, 1, 0, 4, 0, 0, 0, 0); end
      7'b1101111: begin rw = 1; c = pk(0, 2, 2, 0, 0, 5, 0, 0, 0, 0); end
      7'b1100111: if (f3 == 0) begin rw = 1; c = pk(0, 2, 3, 1, 0, 1, 0, 0, 0, 0); end else ok = 0;
      7'b1100011: if (f3 != 2 && f3 != 3) c = pk(0, 0, 1, 0, 1, 3, 0, 0, f3, 0); else ok = 0;
      7'b0000011: begin
        if (f3 == 0 || f3 == 2 || f3 == 3 || f3 == 4) begin
          rw = 1;
          c = pk(1, 1, 0, 1, 0, 1, (f3 == 2) ? 2'd2 : (f3 == 3) ? 2'd3 : 2'd0, f3 == 4, 0, 0);
        end else ok = 0;
      end
      7'b0100011: begin
        if (f3 == 0 || f3 == 2 || f3 == 3) begin
          mw = 1; c = pk(0, 0, 0, 1, 0, 2, f3[1:0], 0, 0, 0);
        end else ok = 0;
      end
      7'b0010011: begin
        rw = 1;
        if (f3 == 0)                       c = pk(0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        else if (f3 == 7)                  c = pk(0, 0, 0, 1, 2, 1, 0, 0, 0, 0);
        else if (f3 == 1 && w[31:26] == 0) c = pk(0, 0, 0, 1, 5, 1, 0, 0, 0, 0);
        else if (f3 == 5)                  c = pk(0, 0, 0, 1, (w[31:26] == 6'b010000) ? 4'd7 : 4'd6, 1, 0, 0, 0, 0);
        else begin ok = 0; rw = 0; end
      end
      7'b0110011: begin
        rw = 1;
        if (f3 == 0 && f7 == 0)              c = pk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        else if (f3 == 0 && f7 == 7'h20)     c = pk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        else if (f3 == 7 && f7 == 0)         c = pk(0, 0, 0, 0, 2, 0, 0, 0, 0, 0);
        else begin ok = 0; rw = 0; end
      end
      7'b0111011: if (f3 == 0 && f7 == 0) begin rw = 1; c = pk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); end else ok = 0;
      default: ok = 0;
    endcase
    return {ok, !ok && w != UNIMP, rw, mw, c};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", tag, what, instr, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [23:0] r = refDecode(instr);
    logic commit = runEn && !haltModel;
    chk("R1", "rs1", 32'(rs1), 32'(instr[19:15]));
    chk("R1", "rs2", 32'(rs2), 32'(instr[24:20]));
    chk("R1", "rd",  32'(rd),  32'(instr[11:7]));
    chk(tag, "ctrlWord", 32'(ctrlWord), 32'(r[19:0]));
    chk(tag, "valid",    32'(valid),    32'(r[23]));
    chk(tag, "illegal",  32'(illegal),  32'(r[22]));
    chk("R8", "regWrite", 32'(regWrite), 32'(r[21] && commit));
    chk("R8", "memWrite", 32'(memWrite), 32'(r[20] && commit));
    chk("R8", "pcUpdate", 32'(pcUpdate), 32'(r[23] && commit));
    chk("R7", "halt",     32'(halt),     32'(haltModel));
  endtask

  task automatic step(logic [31:0] w, logic en, string tag);
    @(negedge clk);
    instr = w;
    runEn = en;
    #1 compareAll(tag);
  endtask

  function automatic logic [31:0] enc(logic [6:0] f7, logic [2:0] f3, logic [6:0] op);
    return {f7, 5'd7, 5'd12, f3, 5'd21, op};
  endfunction

  initial begin
    logic [31:0] validQ[$];
    logic [6:0] ops[8] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
                           7'b1100011, 7'b1100111, 7'b0111011, 7'b0110111};

    // R9: reset state
    repeat (2) @(negedge clk);
    #1 chk("R9", "halt in reset", 32'(halt), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R8: decoding visible while not running, no strobes
    step(enc(7'h00, 3'd0, 7'b0110011), 1'b0, "R8");
    step(enc(7'h00, 3'd3, 7'b0100011), 1'b0, "R8");

    // R2: every supported pattern with run enable high
    validQ = '{enc(0, 0, 7'b0110111), enc(0, 0, 7'b0010111), enc(0, 0, 7'b1101111),
               enc(0, 0, 7'b1100111), enc(0, 0, 7'b1100011), enc(0, 1, 7'b1100011),
               enc(0, 4, 7'b1100011), enc(0, 5, 7'b1100011), enc(0, 6, 7'b1100011),
               enc(0, 7, 7'b1100011), enc(0, 0, 7'b0000011), enc(0, 2, 7'b0000011),
               enc(0, 3, 7'b0000011), enc(0, 4, 7'b0000011), enc(0, 0, 7'b0100011),
               enc(0, 2, 7'b0100011), enc(0, 3, 7'b0100011), enc(7'h55, 0, 7'b0010011),
               enc(7'h55, 7, 7'b0010011), enc(7'h01, 1, 7'b0010011), enc(7'h00, 0, 7'b0110011),
               enc(7'h20, 0, 7'b0110011), enc(7'h00, 7, 7'b0110011), enc(7'h00, 0, 7'b0111011)};
    foreach (validQ[i]) step(validQ[i], 1'b1, "R2");

    // R3: 6-bit shift field
    step(enc(7'b0000001, 3'd1, 7'b0010011), 1'b1, "R3");
    step(enc(7'b0000010, 3'd1, 7'b0010011), 1'b1, "R3");
    step(enc(7'b0100001, 3'd5, 7'b0010011), 1'b1, "R3");
    // R4: overlap resolves to the lower index
    step(enc(7'b0100000, 3'd5, 7'b0010011), 1'b1, "R4");
    step(enc(7'b0000000, 3'd5, 7'b0010011), 1'b1, "R4");
    step(enc(7'b1110000, 3'd5, 7'b0010011), 1'b1, "R4");

    // R5: unmatched words
    step(32'h0000_0000, 1'b1, "R5");
    step(32'hFFFF_FFFF, 1'b1, "R5");
    step(enc(7'h01, 0, 7'b0110011), 1'b1, "R5");
    step(enc(0, 2, 7'b1100011), 1'b1, "R5");
    step(enc(0, 7, 7'b0000011), 1'b1, "R5");
    step(enc(0, 1, 7'b0100011), 1'b1, "R5");

    // mixed random stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w = $urandom;
      if (i % 2 == 0) w[6:0] = ops[i % 8];
      if (w == UNIMP) w = 32'h0;
      step(w, (i % 7) != 0, "R2");
    end

    // R6/R7: unimp while stopped does not halt
    step(UNIMP, 1'b0, "R6");
    step(UNIMP, 1'b0, "R7");
    step(enc(0, 0, 7'b0110011), 1'b1, "R7");
    #1 chk("R7", "no halt when stopped", 32'(halt), 32'd0);
    // unimp while running: halt next edge, sticky
    step(UNIMP, 1'b1, "R6");
    step(enc(0, 0, 7'b0110011), 1'b1, "R8");
    chk("R7", "halt set", 32'(halt), 32'd1);
    step(enc(0, 3, 7'b0100011), 1'b1, "R8");
    step(enc(0, 0, 7'b1101111), 1'b1, "R8");
    step(enc(0, 0, 7'b1101111), 1'b0, "R7");

    // R9: reset clears halt
    @(negedge clk);
    rst = 1'b1;
    step(enc(0, 0, 7'b0110011), 1'b1, "R9");
    rst = 1'b0;
    step(enc(0, 0, 7'b0110011), 1'b1, "R9");
    chk("R9", "halt cleared", 32'(halt), 32'd0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule